// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an asynchronous 512K x 8 static RAM that has active-low select, write and output strobes. The host hands over one single-beat read or write at a time on a valid/ready request channel. The controller then plays the strobe sequence the memory needs, using cycle counts that are worked out from nanosecond timing parameters and the clock period. The response channel is one pulse per finished access and carries the read data. It has no back-pressure, so the host must be able to take a response in any cycle.

Request rules: the host raises `req_valid` with `req_write`, `req_addr` and `req_wdata`, and keeps them stable until it sees `req_ready` high at a rising edge. That edge is the transfer. Only one access is in flight at a time, so `req_ready` stays low until the response has been produced.

A retention request input makes the controller finish any access already under way, deselect the memory, stop driving the data bus and refuse new work. When the input is released, the controller waits one full read cycle time before it accepts a new access.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset: select, write and output strobes are all high; `mem_doe` is 0; `rsp_valid` is 0; `rsp_rdata` is 0; `req_ready` is 1.
- R2: `req_ready` is high only when the controller is idle and `retain_req` is low. A transfer happens on a rising edge where `req_valid` and `req_ready` are both high. The address and write data are latched at that edge.
- R3: A write runs in three phases. First, a turnaround of TA cycles with select low and the other strobes and the driver off. Then a strobe of WP cycles with write enable low, the driver on, and address and data held stable. Then at least one hold cycle with all strobes high and the data still driven.
- R4: A read holds select and output enable low and write enable high for RD cycles. The data input is registered at the edge that ends that window.
- R5: `rsp_valid` is a single-cycle pulse after every access. For writes it appears TA+WP+WH edges after the transfer edge, and for reads RD edges after it.
- R6: `rsp_rdata` holds the data of the most recent read and does not change on writes.
- R7: `mem_doe` is never high while output enable is low. After a read, at least TA cycles pass before the controller drives the bus.
- R8: While `retain_req` is high and no access is in flight: `req_ready` is 0, select is high, `mem_doe` is 0, and a waiting request is not taken.
- R9: An access already accepted when `retain_req` rises runs to completion, and its response is delivered.
- R10: `req_ready` returns high only after RC further rising edges, counted from the edge that first samples `retain_req` low.
- R11: Every cycle count is a ceiling division of a time parameter by the clock period. WP covers both the pulse width and the data setup. RD covers the address, select and output-enable access times and the read cycle time. TA is at least 1. WH is at least 1 and fills out the write cycle time. With a 10 ns clock this gives TA=3, WP=5, WH=1, RD=6 and RC=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle access-complete pulse |
| rsp_rdata | output | 8 | Last read data |
| retain_req | input | 1 | Retention (standby) request |
| mem_addr | output | 19 | Memory address bus |
| mem_dout | output | 8 | Data to drive onto the memory data pins |
| mem_din | input | 8 | Data read from the memory data pins |
| mem_doe | output | 1 | Enable for the data pin drivers |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The assertions assume two things. First, the host keeps a request stable until the transfer edge. Second, `mem_din` is valid by the last cycle of the read window, which the memory guarantees once RD meets the access times. The bench driver therefore changes request fields only at falling edges, and only after a transfer has been seen. A behavioural memory model enforces the data-pin rules on its side: it puts a poison value on `mem_din` until the address access time has passed, and it keeps driving for the release time after a read. Any overlap with `mem_doe`, a write pulse that is too short, or too little data overlap is reported as a failure.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WTURN, ST_WSTRB, ST_WHOLD, ST_RACC, ST_RETAIN, ST_RECOV
  } ctl_state_t;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic doe;
  } strobe_t;

  function automatic int cdiv(int num, int den);
    return (num + den - 1) / den;
  endfunction

  function automatic strobe_t strobes_for(ctl_state_t s);
    strobe_t o;
    case (s)
      ST_WTURN: o = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, doe: 1'b0};
      ST_WSTRB: o = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, doe: 1'b1};
      ST_WHOLD: o = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, doe: 1'b1};
      ST_RACC:  o = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, doe: 1'b0};
      default:  o = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, doe: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] mem_din,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dout  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_din;
    end
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int TA = 3,
  parameter int WP = 5,
  parameter int WH = 1,
  parameter int RD = 6,
  parameter int RC = 6,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          retain_req,
  input  logic          tmr_zero,
  output logic          req_ready,
  output logic          accept,
  output logic          capture,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output strobe_t       strb_q,
  output logic          rsp_valid
);
  ctl_state_t st_q, st_d;
  logic       done;

  assign req_ready = (st_q == ST_IDLE) && !retain_req;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    done     = 1'b0;
    capture  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (retain_req) st_d = ST_RETAIN;
        else if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin st_d = ST_WTURN; tmr_val = CW'(TA - 1); end
          else           begin st_d = ST_RACC;  tmr_val = CW'(RD - 1); end
        end
      end
      ST_WTURN: if (tmr_zero) begin
        st_d = ST_WSTRB; tmr_load = 1'b1; tmr_val = CW'(WP - 1);
      end
      ST_WSTRB: if (tmr_zero) begin
        st_d = ST_WHOLD; tmr_load = 1'b1; tmr_val = CW'(WH - 1);
      end
      ST_WHOLD: if (tmr_zero) begin st_d = ST_IDLE; done = 1'b1; end
      ST_RACC:  if (tmr_zero) begin
        st_d = ST_IDLE; done = 1'b1; capture = 1'b1;
      end
      ST_RETAIN: if (!retain_req) begin
        st_d = ST_RECOV; tmr_load = 1'b1; tmr_val = CW'(RC - 1);
      end
      ST_RECOV: begin
        if (retain_req)    st_d = ST_RETAIN;
        else if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      strb_q    <= strobes_for(ST_IDLE);
      rsp_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      strb_q    <= strobes_for(st_d);
      rsp_valid <= done;
    end
  end

  // R7: the driver phase is only ever entered from the turnaround phase
  p_turn_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WSTRB && $past(st_q) != ST_WSTRB) |-> $past(st_q) == ST_WTURN);
  // R8: retention is held while the request stays high
  p_retain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RETAIN && retain_req) |=> st_q == ST_RETAIN);
  // R10: recovery leaves only to idle or back to retention
  p_recov_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOV) |=> (st_q == ST_RECOV || st_q == ST_IDLE || st_q == ST_RETAIN));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 19,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_WP_PS       = 45000,
  parameter int T_DS_PS       = 25000,
  parameter int T_WC_PS       = 55000,
  parameter int T_RC_PS       = 55000,
  parameter int T_AA_PS       = 55000,
  parameter int T_OE_PS       = 30000,
  parameter int T_HZ_PS       = 30000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          retain_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  input  logic [DW-1:0] mem_din,
  output logic          mem_doe,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);
  // R11: cycle counts by ceiling division
  localparam int WP_RAW = cdiv(T_WP_PS, CLK_PERIOD_PS);
  localparam int DS_RAW = cdiv(T_DS_PS, CLK_PERIOD_PS);
  localparam int WP_CYC = (WP_RAW > DS_RAW) ? WP_RAW : DS_RAW;
  localparam int TA_RAW = cdiv(T_HZ_PS, CLK_PERIOD_PS);
  localparam int TA_CYC = (TA_RAW < 1) ? 1 : TA_RAW;
  localparam int WC_RAW = cdiv(T_WC_PS, CLK_PERIOD_PS);
  localparam int WH_GAP = WC_RAW - TA_CYC - WP_CYC;
  localparam int WH_CYC = (WH_GAP < 1) ? 1 : WH_GAP;
  localparam int RC_CYC = cdiv(T_RC_PS, CLK_PERIOD_PS);
  localparam int AA_RAW = cdiv(T_AA_PS, CLK_PERIOD_PS);
  localparam int OE_RAW = cdiv(T_OE_PS, CLK_PERIOD_PS);
  localparam int RD_A   = (AA_RAW > RC_CYC) ? AA_RAW : RC_CYC;
  localparam int RD_CYC = (RD_A > OE_RAW) ? RD_A : OE_RAW;
  localparam int MX_A   = (WP_CYC > TA_CYC) ? WP_CYC : TA_CYC;
  localparam int MX_B   = (RD_CYC > WH_CYC) ? RD_CYC : WH_CYC;
  localparam int MX_C   = (MX_A > MX_B) ? MX_A : MX_B;
  localparam int MX_ALL = (MX_C > RC_CYC) ? MX_C : RC_CYC;
  localparam int CW     = $clog2(MX_ALL + 1);

  logic          accept, capture, tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  strobe_t       strb;

  sram_seq_fsm #(
    .TA(TA_CYC), .WP(WP_CYC), .WH(WH_CYC), .RD(RD_CYC), .RC(RC_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .retain_req(retain_req), .tmr_zero(tmr_zero), .req_ready(req_ready),
    .accept(accept), .capture(capture), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .strb_q(strb), .rsp_valid(rsp_valid)
  );

  sram_cyc_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_data_path #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .mem_din(mem_din),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .rsp_rdata(rsp_rdata)
  );

  assign mem_cs_n = strb.cs_n;
  assign mem_we_n = strb.we_n;
  assign mem_oe_n = strb.oe_n;
  assign mem_doe  = strb.doe;

  // R3: write strobe only under select, with outputs off and driver on
  p_we_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_doe));
  // R3: address steady while selected
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R3: write data steady across the strobe
  p_wdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dout));
  // R7: no drive while memory outputs are enabled
  p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_doe);
  // R5: response is a single-cycle pulse
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8: a deselected memory stays deselected under retention
  p_retain_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retain_req) && retain_req && $past(mem_cs_n)) |-> mem_cs_n);
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int WP_C = 5, DW_C = 3, AA_C = 6, HZ_C = 3, RC_C = 6;
  localparam int LAT_W = 9, LAT_R = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_write = 0, retain_req = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_doe, mem_cs_n, mem_we_n, mem_oe_n;
  logic [7:0] rsp_rdata, mem_dout, mem_din;
  logic [18:0] mem_addr;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .retain_req(retain_req),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
    .mem_doe(mem_doe), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural memory model
  logic [7:0] mem [int];
  int mem_gen = 0, rd_cnt = 0, hz_cnt = 0, wlow = 0, wdrv = 0;
  logic [18:0] waddr0;
  logic [7:0] wdat;
  logic rd_act;
  assign rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;

  always @(mem_addr, rd_act, rd_cnt, mem_gen) begin
    if (rd_act && rd_cnt + 1 >= AA_C)
      mem_din = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    else
      mem_din = 8'hEE;
  end

  int rec_cnt = 0;
  bit rec_armed = 0;
  always @(posedge clk) if (rst_n) begin
    if (mem_doe && (rd_act || hz_cnt > 0))
      chk(0, "R7", "driver on while memory drives", 1, 0);
    if (rd_act) begin rd_cnt <= rd_cnt + 1; hz_cnt <= HZ_C; end
    else begin rd_cnt <= 0; if (hz_cnt > 0) hz_cnt <= hz_cnt - 1; end
    if (!mem_cs_n && !mem_we_n) begin
      if (wlow == 0) waddr0 <= mem_addr;
      else if (mem_addr != waddr0) chk(0, "R3", "address moved in strobe", int'(mem_addr), int'(waddr0));
      wlow <= wlow + 1;
      if (mem_doe) wdrv <= wdrv + 1;
      wdat <= mem_dout;
    end else if (wlow > 0) begin
      chk(wlow >= WP_C, "R3", "write pulse cycles", wlow, WP_C);
      chk(wdrv >= DW_C, "R3", "data overlap cycles", wdrv, DW_C);
      mem[int'(waddr0)] = wdat;
      mem_gen++;
      wlow <= 0; wdrv <= 0;
    end
    if (retain_req) begin rec_cnt <= 0; rec_armed <= 1; end
    else if (rec_armed) begin
      if (!mem_cs_n) begin
        chk(rec_cnt >= RC_C, "R10", "cycles before first select", rec_cnt, RC_C);
        rec_armed <= 0;
      end else rec_cnt <= rec_cnt + 1;
    end
  end

  // scoreboard
  typedef struct { bit wr; logic [7:0] d; int acc; } exp_t;
  exp_t q[$];
  logic [7:0] shadow [int];
  logic [7:0] last_rd = 8'h00;
  int cyc = 0;
  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (q.size() == 0) chk(0, "R5", "unexpected response", 1, 0);
    else begin
      exp_t e;
      e = q.pop_front();
      if (e.wr) begin
        chk(cyc - e.acc == LAT_W + 1, "R5", "write latency", cyc - e.acc - 1, LAT_W);
        chk(rsp_rdata == last_rd, "R6", "read data moved on write", rsp_rdata, last_rd);
      end else begin
        chk(cyc - e.acc == LAT_R + 1, "R5", "read latency", cyc - e.acc - 1, LAT_R);
        chk(rsp_rdata == e.d, "R4", "read data", rsp_rdata, e.d);
        last_rd = e.d;
      end
    end
  end

  function automatic exp_t make_exp(bit wr, logic [18:0] a, logic [7:0] d);
    exp_t e;
    e.wr = wr;
    e.acc = cyc;
    if (wr) begin shadow[int'(a)] = d; e.d = d; end
    else e.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    return e;
  endfunction

  // driver: starts and ends at a falling edge (R2)
  task automatic access(bit wr, logic [18:0] a, logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    q.push_back(make_exp(wr, a, d));
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n == 1, "R1", "cs_n", mem_cs_n, 1);
    chk(mem_we_n == 1, "R1", "we_n", mem_we_n, 1);
    chk(mem_oe_n == 1, "R1", "oe_n", mem_oe_n, 1);
    chk(mem_doe == 0, "R1", "doe", mem_doe, 0);
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    chk(rsp_rdata == 0, "R1", "rsp_rdata", rsp_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);

    // R2/R3/R4/R11: boundary addresses and data patterns
    access(1, 19'h00000, 8'hA5);
    access(1, 19'h7FFFF, 8'h5A);
    access(1, 19'h12345, 8'hFF);
    access(1, 19'h00001, 8'h00);
    access(0, 19'h00000, 8'h00);
    access(0, 19'h7FFFF, 8'h00);
    access(0, 19'h12345, 8'h00);
    access(0, 19'h00001, 8'h00);
    access(0, 19'h00100, 8'h00);
    // R7: read immediately followed by write, then readback (R6 on write)
    for (int i = 0; i < 6; i++) begin
      access(0, 19'(i * 19'h0A3C1), 8'h00);
      access(1, 19'(i * 19'h0A3C1), 8'(8'h3C ^ (i * 37)));
      access(0, 19'(i * 19'h0A3C1), 8'h00);
    end
    drain();

    // R8: retention blocks requests
    retain_req = 1;
    repeat (2) @(negedge clk);
    chk(req_ready == 0, "R8", "ready in retention", req_ready, 0);
    req_valid = 1; req_write = 1; req_addr = 19'h00055; req_wdata = 8'h11;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(mem_cs_n == 1 && mem_doe == 0, "R8", "deselected and undriven", {mem_cs_n, mem_doe}, 2);
    end
    chk(!shadow.exists(32'h55), "R8", "request not taken", 0, 0);
    // R10: recovery
    retain_req = 0;
    begin
      int n;
      n = 0;
      do begin @(negedge clk); n++; end while (!req_ready && n < 50);
      chk(n == RC_C + 1, "R10", "edges until ready", n, RC_C + 1);
    end
    q.push_back(make_exp(1, 19'h00055, 8'h11));
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    drain();

    // R9: retention raised during an access
    access(1, 19'h04242, 8'hC3);
    retain_req = 1;
    drain();
    chk(q.size() == 0, "R9", "in-flight access finished", q.size(), 0);
    chk(mem_cs_n == 1, "R9", "deselected after finish", mem_cs_n, 1);
    retain_req = 0;
    access(0, 19'h04242, 8'h00);
    access(0, 19'h00055, 8'h00);
    drain();
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule